// File: doc/BRIEF.md
# I2C Single-Byte Slave

This block is an I2C bus slave that holds a single 8-bit data register. It runs on a system clock at least eight times faster than SCL. SCL and SDA each pass through a synchronizer and one more registered stage that is used to find edges. Start, repeated start and stop are detected while SCL is high. The block drives SDA as an open-drain line through an output enable. When SCL must be held low, a second output enable pulls it low.

After a start, the block takes in seven address bits, MSB first, followed by a direction bit. The address matches when the received address and the device address agree in every bit that is set in `addrMask`. A bit cleared in the mask makes that address bit a don't-care, so one slave can answer a group of addresses. On a match the slave acknowledges. When the master writes, each byte is acknowledged, stored, and signalled with a one-cycle strobe. When the master reads, the register is shifted out and reloaded for each further byte the master acknowledges. On a mismatch the slave stays silent and counts SCL falling edges to pass over whole bytes until the next stop or start. The local logic can write the register between bus bytes. It can also stretch the clock after a received byte.

Top module: `i2c_reg_slave`

## Requirements
- R1: While reset is active and directly after it, `sdaOe` and `sclOe` are low, `wrData` is 0x00, and no strobe is raised.
- R2: An address byte is acknowledged, with SDA held low for the ninth SCL pulse, when `((rx_addr ^ DEV_ADDR) & addrMask) == 0`. DEV_ADDR defaults to 0x50. The address occupies bits 7..1 of the first byte and the direction occupies bit 0, where 1 means the master reads. `sdaOe` only ever rises while SCL is low.
- R3: On an address mismatch, SDA is never driven. Bytes that follow are skipped without any acknowledge or strobe, and the register keeps its value.
- R4: In a master write, each data byte is acknowledged and stored. `wrStrobe` pulses for exactly one cycle, and `wrData` shows the new byte in that same cycle.
- R5: In a master read, the register is sent MSB first. A 1 releases SDA and a 0 pulls it low. `sdaOe` never changes while SCL is high.
- R6: After each transmitted byte, SDA is released. A master ACK (SDA low) reloads the register, sends it again and pulses `rdStrobe` for one cycle. A master NACK leaves SDA released until the next start or stop.
- R7: A start or repeated start at any point restarts address reception. A stop returns the block to idle, and a byte cut short by a stop is not stored.
- R8: If `hold` is high when the acknowledge of a written byte ends, `sclOe` holds SCL low until `hold` falls. `sclOe` is never high unless `hold` was high in the cycle before.
- R9: A one-cycle `locWe` loads `locData` into the register. The next master read returns this value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SCL level seen on the bus |
| sdaIn | input | 1 | SDA level seen on the bus |
| addrMask | input | ADDR_W | Address compare mask, where a 1 means the bit must match |
| hold | input | 1 | Request to stretch SCL after a received byte |
| locWe | input | 1 | Local write enable for the data register |
| locData | input | ADDR_W+1 | Local write data |
| sdaOe | output | 1 | Pulls SDA low when high |
| sclOe | output | 1 | Pulls SCL low when high |
| wrStrobe | output | 1 | One-cycle pulse when a bus byte is stored |
| wrData | output | ADDR_W+1 | Current register contents |
| rdStrobe | output | 1 | One-cycle pulse when a byte is loaded for transmission |

## Verification
Some rules are checked on every cycle. SDA output timing must hold: the enable never changes while SCL is high, and it only ever rises while SCL is low. Clock stretching must always follow the hold request. Both strobes must be single-cycle pulses that never occur together. Other behaviour can only be shown by the bench scenarios that drive a bus master: the masked address decision, silence after a miss, the order of the transmitted bits, reloading on a master ACK, discarding a byte cut short by a stop, and the value a local write makes visible to a later read.

// File: rtl/i2c_slave_pkg.sv
package i2c_slave_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_STRETCH,
    ST_RD,
    ST_RD_ACK,
    ST_WAIT,
    ST_SKIP
  } slvState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic rxShift;
    logic txLoad;
    logic txShift;
    logic store;
  } dpCtl_t;

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaBit,
  output logic sclRise,
  output logic sclFall,
  output logic startCond,
  output logic stopCond
);

  logic [STAGES-1:0] sclPipe, sdaPipe;
  logic sclDly, sdaDly;
  logic sclNow, sdaNow;

  // idle bus is high, so reset to ones to avoid a false condition
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclDly  <= 1'b1;
      sdaDly  <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclDly  <= sclPipe[STAGES-1];
      sdaDly  <= sdaPipe[STAGES-1];
    end
  end

  assign sclNow    = sclPipe[STAGES-1];
  assign sdaNow    = sdaPipe[STAGES-1];
  assign sdaBit    = sdaNow;
  assign sclRise   = sclNow & ~sclDly;
  assign sclFall   = ~sclNow & sclDly;
  assign startCond = sclNow & sclDly & sdaDly & ~sdaNow;
  assign stopCond  = sclNow & sclDly & ~sdaDly & sdaNow;

endmodule

// File: rtl/i2c_slave_dp.sv
module i2c_slave_dp import i2c_slave_pkg::*; #(
  parameter int W  = 8,
  localparam int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtl_t        ctl,
  input  logic          sdaBit,
  input  logic          locWe,
  input  logic [W-1:0]  locData,
  output logic [W-1:0]  shiftReg,
  output logic [CW-1:0] bitCnt,
  output logic [W-1:0]  dataReg
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (ctl.txLoad) begin
      shiftReg <= dataReg;
    end else if (ctl.rxShift) begin
      shiftReg <= {shiftReg[W-2:0], sdaBit};
    end else if (ctl.txShift) begin
      shiftReg <= {shiftReg[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (ctl.cntClr) begin
      bitCnt <= '0;
    end else if (ctl.cntInc) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  // bus store wins over a simultaneous local write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
    end else if (ctl.store) begin
      dataReg <= shiftReg;
    end else if (locWe) begin
      dataReg <= locData;
    end
  end

endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl import i2c_slave_pkg::*; #(
  parameter int          AW       = 7,
  parameter logic [AW-1:0] DEV_ADDR = 7'h50,
  localparam int         W        = AW + 1,
  localparam int         CW       = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sclRise,
  input  logic          sclFall,
  input  logic          startCond,
  input  logic          stopCond,
  input  logic          sdaBit,
  input  logic          hold,
  input  logic [AW-1:0] addrMask,
  input  logic [W-1:0]  shiftReg,
  input  logic [CW-1:0] bitCnt,
  output dpCtl_t        ctl,
  output logic          sdaOe,
  output logic          sclOe,
  output logic          wrStrobe,
  output logic          rdStrobe
);

  slvState_t state, nextState;
  logic ackSeen, nextAck, nextWr, nextRd;
  logic addrHit, byteDone, lastTxBit;

  assign addrHit   = (((shiftReg[W-1 -: AW]) ^ DEV_ADDR) & addrMask) == '0;
  assign byteDone  = (bitCnt == CW'(W));
  assign lastTxBit = (bitCnt == CW'(W - 1));

  always_comb begin
    nextState = state;
    nextAck   = ackSeen;
    nextWr    = 1'b0;
    nextRd    = 1'b0;
    ctl       = '0;
    if (startCond) begin
      nextState  = ST_ADDR;
      ctl.cntClr = 1'b1;
    end else if (stopCond) begin
      nextState = ST_IDLE;
    end else begin
      case (state)
        ST_ADDR, ST_WR: begin
          if (sclRise && !byteDone) begin
            ctl.rxShift = 1'b1;
            ctl.cntInc  = 1'b1;
          end else if (sclFall && byteDone) begin
            if (state == ST_WR)  nextState = ST_WR_ACK;
            else if (addrHit)    nextState = ST_ADDR_ACK;
            else                 nextState = ST_SKIP;
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            ctl.cntClr = 1'b1;
            if (shiftReg[0]) begin
              nextState  = ST_RD;
              ctl.txLoad = 1'b1;
              nextRd     = 1'b1;
            end else begin
              nextState = ST_WR;
            end
          end
        end
        ST_WR_ACK: begin
          if (sclFall) begin
            ctl.store  = 1'b1;
            ctl.cntClr = 1'b1;
            nextWr     = 1'b1;
            nextState  = hold ? ST_STRETCH : ST_WR;
          end
        end
        ST_STRETCH: begin
          if (!hold) nextState = ST_WR;
        end
        ST_RD: begin
          if (sclFall) begin
            if (lastTxBit) begin
              nextState = ST_RD_ACK;
            end else begin
              ctl.txShift = 1'b1;
              ctl.cntInc  = 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (sclRise) begin
            nextAck = ~sdaBit;
          end else if (sclFall) begin
            if (ackSeen) begin
              nextState  = ST_RD;
              ctl.txLoad = 1'b1;
              ctl.cntClr = 1'b1;
              nextRd     = 1'b1;
            end else begin
              nextState = ST_WAIT;
            end
          end
        end
        ST_SKIP: begin
          // eight data falls plus the acknowledge fall per skipped byte
          if (sclFall) begin
            if (byteDone) ctl.cntClr = 1'b1;
            else          ctl.cntInc = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      ackSeen  <= 1'b0;
      wrStrobe <= 1'b0;
      rdStrobe <= 1'b0;
    end else begin
      state    <= nextState;
      ackSeen  <= nextAck;
      wrStrobe <= nextWr;
      rdStrobe <= nextRd;
    end
  end

  always_comb begin
    case (state)
      ST_ADDR_ACK, ST_WR_ACK: sdaOe = 1'b1;
      ST_RD:                  sdaOe = ~shiftReg[W-1];
      default:                sdaOe = 1'b0;
    endcase
  end

  assign sclOe = (state == ST_STRETCH);

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave import i2c_slave_pkg::*; #(
  parameter int              ADDR_W      = 7,
  parameter logic [ADDR_W-1:0] DEV_ADDR  = 7'h50,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] addrMask,
  input  logic              hold,
  input  logic              locWe,
  input  logic [ADDR_W:0]   locData,
  output logic              sdaOe,
  output logic              sclOe,
  output logic              wrStrobe,
  output logic [ADDR_W:0]   wrData,
  output logic              rdStrobe
);

  localparam int W  = ADDR_W + 1;
  localparam int CW = $clog2(W + 1);

  logic sdaBit, sclRise, sclFall, startCond, stopCond;
  logic [W-1:0]  shiftReg;
  logic [CW-1:0] bitCnt;
  dpCtl_t ctl;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaBit(sdaBit), .sclRise(sclRise), .sclFall(sclFall),
    .startCond(startCond), .stopCond(stopCond)
  );

  i2c_slave_ctrl #(.AW(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startCond(startCond), .stopCond(stopCond), .sdaBit(sdaBit),
    .hold(hold), .addrMask(addrMask), .shiftReg(shiftReg),
    .bitCnt(bitCnt), .ctl(ctl), .sdaOe(sdaOe), .sclOe(sclOe),
    .wrStrobe(wrStrobe), .rdStrobe(rdStrobe)
  );

  i2c_slave_dp #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdaBit(sdaBit),
    .locWe(locWe), .locData(locData), .shiftReg(shiftReg),
    .bitCnt(bitCnt), .dataReg(wrData)
  );

endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaOe,
  input logic sclOe,
  input logic hold,
  input logic wrStrobe,
  input logic rdStrobe
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |-> (!sdaOe && !sclOe));

  assert_oe_rise_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclIn);

  assert_sda_steady_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn)) |-> $stable(sdaOe));

  assert_wr_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(wrStrobe && rdStrobe));

  assert_rd_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe |=> !rdStrobe);

  assert_stretch_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    sclOe |-> $past(hold));

endmodule

bind i2c_reg_slave i2c_reg_slave_chk u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe), .sclOe(sclOe),
  .hold(hold), .wrStrobe(wrStrobe), .rdStrobe(rdStrobe)
);

// File: tb/sim_i2c_reg_slave.sv
module sim_i2c_reg_slave;

  localparam int Q = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic sclIn, sdaIn;
  logic [6:0] addrMask = 7'h7F;
  logic hold = 1'b0, locWe = 1'b0;
  logic [7:0] locData = 8'h00;
  logic sdaOe, sclOe, wrStrobe, rdStrobe;
  logic [7:0] wrData;

  int nChk = 0, nFail = 0;

  typedef struct {
    bit isRd;
    logic [7:0] val;
  } sbItem_t;
  sbItem_t sbq[$];

  always #10 clk = ~clk;

  assign sclIn = mScl & ~sclOe;
  assign sdaIn = mSda & ~sdaOe;

  i2c_reg_slave u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrMask(addrMask), .hold(hold), .locWe(locWe), .locData(locData),
    .sdaOe(sdaOe), .sclOe(sclOe), .wrStrobe(wrStrobe), .wrData(wrData),
    .rdStrobe(rdStrobe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expectEv(input bit isRd, input logic [7:0] v);
    sbItem_t it;
    it.isRd = isRd;
    it.val  = v;
    sbq.push_back(it);
  endtask

  // monitor: every strobe must match the next expected item
  always @(negedge clk) begin
    if (rstN && (wrStrobe || rdStrobe)) begin
      nChk++;
      if (sbq.size() == 0) begin
        nFail++;
        $display("FAIL R4/R6 unexpected strobe actual=wr%0b rd%0b expected=none", wrStrobe, rdStrobe);
      end else begin
        sbItem_t it;
        it = sbq.pop_front();
        if (it.isRd != rdStrobe || it.val !== wrData) begin
          nFail++;
          $display("FAIL R4/R6 strobe actual=rd%0b %0h expected=rd%0b %0h",
                   rdStrobe, wrData, it.isRd, it.val);
        end
      end
    end
  end

  task automatic busStart();
    mSda = 1'b1; tick(Q);
    mScl = 1'b1; tick(Q);
    mSda = 1'b0; tick(Q);
    mScl = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    mSda = 1'b0; tick(Q);
    mScl = 1'b1; tick(Q);
    mSda = 1'b1; tick(Q);
  endtask

  task automatic bitXfer(input logic b, output logic r);
    mSda = b; tick(Q);
    mScl = 1'b1;
    while (!sclIn) tick(1);
    tick(Q);
    r = sdaIn;
    tick(Q);
    mScl = 1'b0; tick(Q);
  endtask

  task automatic writeByte(input logic [7:0] v, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bitXfer(v[i], r);
    bitXfer(1'b1, ack);
  endtask

  task automatic readByte(input logic masterAck, output logic [7:0] v);
    logic r;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      bitXfer(1'b1, r);
      v = {v[6:0], r};
    end
    bitXfer(masterAck ? 1'b0 : 1'b1, r);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    tick(3);
    chk("R1 sdaOe in reset", sdaOe, 0);
    chk("R1 sclOe in reset", sclOe, 0);
    rstN = 1'b1;
    tick(3);
    chk("R1 wrData after reset", wrData, 8'h00);
    chk("R1 strobes after reset", {wrStrobe, rdStrobe}, 0);

    // master write, two bytes
    busStart();
    writeByte(8'hA0, a); chk("R2 address ack 0x50", a, 0);
    expectEv(0, 8'h3C);
    writeByte(8'h3C, a); chk("R4 data ack 0x3C", a, 0);
    expectEv(0, 8'hC5);
    writeByte(8'hC5, a); chk("R4 data ack 0xC5", a, 0);
    busStop();
    chk("R4 register holds last byte", wrData, 8'hC5);

    // master read: ACK then NACK
    busStart();
    expectEv(1, 8'hC5);
    writeByte(8'hA1, a); chk("R2 read address ack", a, 0);
    expectEv(1, 8'hC5);
    readByte(1'b1, d); chk("R5 first read byte", d, 8'hC5);
    readByte(1'b0, d); chk("R6 reload after master ack", d, 8'hC5);
    tick(2);
    chk("R6 SDA released after NACK", sdaOe, 0);
    busStop();

    // address miss: no acknowledge, bytes skipped
    busStart();
    writeByte(8'hA2, a); chk("R3 no ack for 0x51", a, 1);
    writeByte(8'h00, a); chk("R3 skipped byte not acked", a, 1);
    writeByte(8'h00, a); chk("R3 second skipped byte not acked", a, 1);
    busStop();
    chk("R3 register unchanged after miss", wrData, 8'hC5);

    // widened mask, then repeated start into a read
    addrMask = 7'h7C;
    busStart();
    writeByte(8'hA8, a); chk("R2 0x54 still misses under mask", a, 1);
    busStart();
    writeByte(8'hA6, a); chk("R2 masked match 0x53", a, 0);
    expectEv(0, 8'h81);
    writeByte(8'h81, a); chk("R4 data ack 0x81", a, 0);
    busStart();
    expectEv(1, 8'h81);
    writeByte(8'hA5, a); chk("R7 repeated start read 0x52", a, 0);
    readByte(1'b0, d); chk("R5 read after repeated start", d, 8'h81);
    busStop();
    addrMask = 7'h7F;

    // local write then read back
    locData = 8'h5A; locWe = 1'b1; tick(1); locWe = 1'b0; tick(1);
    chk("R9 local write visible", wrData, 8'h5A);
    busStart();
    expectEv(1, 8'h5A);
    writeByte(8'hA1, a); chk("R9 read address ack", a, 0);
    readByte(1'b0, d); chk("R9 read returns local value", d, 8'h5A);
    busStop();

    // repeated start after a miss, then stop mid byte
    busStart();
    writeByte(8'h66, a); chk("R7 miss before restart", a, 1);
    busStart();
    writeByte(8'hA0, a); chk("R7 ack after restart", a, 0);
    bitXfer(1'b1, a); bitXfer(1'b0, a); bitXfer(1'b1, a);
    busStop();
    tick(5);
    chk("R7 partial byte discarded", wrData, 8'h5A);

    // clock stretch
    busStart();
    writeByte(8'hA0, a); chk("R8 address ack", a, 0);
    hold = 1'b1;
    expectEv(0, 8'h99);
    writeByte(8'h99, a); chk("R8 data ack", a, 0);
    tick(5);
    chk("R8 sclOe while hold", sclOe, 1);
    chk("R8 SCL held low", sclIn, 0);
    hold = 1'b0;
    tick(3);
    chk("R8 sclOe released", sclOe, 0);
    busStop();

    tick(10);
    chk("R4 scoreboard drained", sbq.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule